// File: doc/BRIEF.md
# Periodic Reload Down-Counter Timer

This block is a small timer peripheral with a word-wide register port. A counter, 16 bits wide by default, counts down once on each cycle where the tick strobe is high while the timer runs. A tick on a count of zero loads the count from the reload register and gives a one-cycle wrap pulse, so the timer keeps running at a fixed period. The system supplies the tick strobe, normally once per microsecond.

Software starts the timer by writing the control register with the start bit set. A second control bit acts as a soft reset. It stops the timer and clears the stored state. Clearing the start bit only changes the stored control word, so there is no way to halt a running timer except by soft or hardware reset. A write to the reload register also loads the live count at once.

The register port is a plain control port with no handshake. A write takes effect on the clock edge where `wr_en` is high. Reads are combinational from `addr`, so the port never stalls and cannot apply back-pressure.

Top module: `tmr_reload_timer`

## Requirements
- R1: After hardware reset the control, reload and count registers all read zero, the timer is stopped and `wrap` is low.
- R2: A write to offset 0x00 with bit 1 set is a soft reset. It stops the timer and clears control, reload and count to zero. The rest of the written word is discarded, including bit 0.
- R3: A write to offset 0x00 with bit 0 set and bit 1 clear stores the full 32-bit word in control and starts the timer.
- R4: A write to offset 0x00 with bit 0 clear stores the word but does not stop a timer that is already running.
- R5: A write to offset 0x08 keeps only the low CNT_W bits as the reload value. On the same edge it loads the count with that value. Reload reads back zero-extended.
- R6: Offset 0x0C returns the count zero-extended from CNT_W bits, and writes to it have no effect. Any offset other than 0x00, 0x08 and 0x0C reads zero and ignores writes.
- R7: The count changes only on an edge where `tick_en` is high and the timer is running. On such an edge a non-zero count drops by exactly one.
- R8: A tick on a count of zero loads the reload value and raises `wrap` for one cycle. With a steady tick, the wrap period is (reload+1) ticks.
- R9: With a reload value of zero and the timer running, the count stays at zero and never wraps to all ones. `wrap` is raised on every tick.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | One-cycle count strobe |
| wr_en | input | 1 | Register write strobe |
| addr | input | ADDR_W | Byte offset into the register window |
| wdata | input | DATA_W | Write data |
| rdata | output | DATA_W | Read data for `addr`, combinational |
| wrap | output | 1 | One-cycle pulse on each reload event |

## Verification
The bench builds the timer with CNT_W=6, which narrows the counter to 64 values. The sweep can then run every reload value from 0 to 63 and measure each wrap period against reload+1. A narrow counter also makes the truncation of a full 32-bit reload write visible. A second pass divides the tick strobe by three to check that the period scales with ticks rather than clock cycles.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int OFF_CTRL   = 'h00;
  localparam int OFF_RELOAD = 'h08;
  localparam int OFF_COUNT  = 'h0C;
  localparam int BIT_START  = 0;
  localparam int BIT_SRST   = 1;
endpackage

// File: rtl/tmr_regfile.sv
module tmr_regfile
  import tmr_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [CNT_W-1:0]  count,
  output logic [DATA_W-1:0] rdata,
  output logic [CNT_W-1:0]  reload,
  output logic              srst,
  output logic              start,
  output logic              load
);
  localparam logic [ADDR_W-1:0] A_CTRL   = ADDR_W'(OFF_CTRL);
  localparam logic [ADDR_W-1:0] A_RELOAD = ADDR_W'(OFF_RELOAD);
  localparam logic [ADDR_W-1:0] A_COUNT  = ADDR_W'(OFF_COUNT);

  logic [DATA_W-1:0] ctrl_q;
  logic [CNT_W-1:0]  reload_q;
  logic              ctrl_wr;

  assign ctrl_wr = wr_en && (addr == A_CTRL);
  assign srst    = ctrl_wr && wdata[BIT_SRST];
  assign start   = ctrl_wr && !wdata[BIT_SRST] && wdata[BIT_START];
  assign load    = wr_en && (addr == A_RELOAD);
  assign reload  = reload_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q   <= '0;
      reload_q <= '0;
    end else if (srst) begin
      ctrl_q   <= '0;
      reload_q <= '0;
    end else begin
      if (ctrl_wr) ctrl_q <= wdata;
      if (load)    reload_q <= wdata[CNT_W-1:0];
    end
  end

  always_comb begin
    unique case (addr)
      A_CTRL:   rdata = ctrl_q;
      A_RELOAD: rdata = DATA_W'(reload_q);
      A_COUNT:  rdata = DATA_W'(count);
      default:  rdata = '0;
    endcase
  end

  // R2
  srst_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    srst |=> (ctrl_q == '0 && reload_q == '0));

  // R3
  ctrl_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_wr && !srst) |=> (ctrl_q == $past(wdata)));
endmodule

// File: rtl/tmr_counter.sv
module tmr_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_en,
  input  logic             srst,
  input  logic             start,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic [CNT_W-1:0] reload,
  output logic [CNT_W-1:0] count,
  output logic             wrap
);
  logic             run_q;
  logic [CNT_W-1:0] cnt_q;
  logic             wrap_q;
  logic             step;

  assign step  = run_q && tick_en && !srst && !load;
  assign count = cnt_q;
  assign wrap  = wrap_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= 1'b0;
      cnt_q  <= '0;
      wrap_q <= 1'b0;
    end else begin
      wrap_q <= 1'b0;
      if (srst) begin
        run_q <= 1'b0;
        cnt_q <= '0;
      end else begin
        if (start) run_q <= 1'b1;
        if (load) begin
          cnt_q <= load_val;
        end else if (step) begin
          if (cnt_q == '0) begin
            cnt_q  <= reload;
            wrap_q <= 1'b1;
          end else begin
            cnt_q <= cnt_q - 1'b1;
          end
        end
      end
    end
  end

  // R8
  wrap_from_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_q |-> ($past(cnt_q) == '0));

  // R7
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick_en && !srst && !load) |=> $stable(cnt_q));

  // R7
  step_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && tick_en && cnt_q != '0 && !srst && !load) |=> (cnt_q == $past(cnt_q) - 1'b1));

  // R5
  load_now_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (load && !srst) |=> (cnt_q == $past(load_val)));

  // R9
  zero_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step && cnt_q == '0 && reload == '0) |=> (cnt_q == '0 && wrap_q));

  // R4
  keep_running_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && !srst) |=> run_q);
endmodule

// File: rtl/tmr_reload_timer.sv
module tmr_reload_timer #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_en,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              wrap
);
  logic [CNT_W-1:0] count;
  logic [CNT_W-1:0] reload;
  logic             srst;
  logic             start;
  logic             load;

  tmr_regfile #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)) u_regs (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (wr_en),
    .addr   (addr),
    .wdata  (wdata),
    .count  (count),
    .rdata  (rdata),
    .reload (reload),
    .srst   (srst),
    .start  (start),
    .load   (load)
  );

  tmr_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick_en  (tick_en),
    .srst     (srst),
    .start    (start),
    .load     (load),
    .load_val (wdata[CNT_W-1:0]),
    .reload   (reload),
    .count    (count),
    .wrap     (wrap)
  );
endmodule

// File: tb/tmr_reload_timer_tb.sv
module tmr_reload_timer_tb;
  localparam int CLK_PERIOD = 10;
  localparam int CW = 6;
  localparam int LIM = 2000;

  logic        clk = 0;
  logic        rst_n = 0;
  logic        wr_en = 0;
  logic [7:0]  addr = 0;
  logic [31:0] wdata = 0;
  logic [31:0] rdata;
  logic        wrap;
  logic        tick_on = 0;
  int          tick_every = 1;
  int          phase = 0;
  logic        tick_en;
  int          ntests = 0;
  int          nfail = 0;

  assign tick_en = tick_on && (phase == 0);

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(negedge clk) phase <= (phase + 1 >= tick_every) ? 0 : phase + 1;

  tmr_reload_timer #(.ADDR_W(8), .DATA_W(32), .CNT_W(CW)) u_dut (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .wr_en(wr_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .wrap(wrap)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    ntests++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    addr = a;
    #1 d = rdata;
  endtask

  task automatic wait_wrap(input string tag, output int n);
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!wrap && n < LIM);
    if (n >= LIM) chk(tag, 0, 1);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    nfail++;
    $display("FAIL watchdog expired, all requirements");
    $display("[TB] %0d tests run, %0d failed", ntests, nfail);
    $finish;
  end

  initial begin
    logic [31:0] v, a0, b0;
    int n;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R1 reset state
    rd(8'h00, v); chk("R1 ctrl", v, 0);
    rd(8'h08, v); chk("R1 reload", v, 0);
    rd(8'h0C, v); chk("R1 count", v, 0);
    chk("R1 wrap", {31'b0, wrap}, 0);

    // R5 truncation and immediate load
    wr(8'h08, 32'hFFFF_FFA5);
    rd(8'h08, v); chk("R5 reload trunc", v, 32'hA5 & 32'h3F);
    rd(8'h0C, v); chk("R5 count loaded", v, 32'hA5 & 32'h3F);

    // R7 stopped timer ignores ticks
    wr(8'h08, 9);
    tick_on = 1;
    repeat (6) @(negedge clk);
    rd(8'h0C, v); chk("R7 stopped hold", v, 9);
    chk("R7 stopped no wrap", {31'b0, wrap}, 0);

    // R6 count write ignored, unmapped offsets
    wr(8'h0C, 32'h33);
    rd(8'h0C, v); chk("R6 count write ignored", v, 9);
    wr(8'h04, 32'hFFFF);
    rd(8'h04, v); chk("R6 unmapped read", v, 0);
    wr(8'h09, 32'h11);
    rd(8'h08, v); chk("R6 misaligned ignored", v, 9);
    rd(8'h00, v); chk("R6 ctrl untouched", v, 0);
    rd(8'h10, v); chk("R6 unmapped read hi", v, 0);

    // R3 full word stored and start
    wr(8'h08, 40);
    wr(8'h00, 32'hDEAD_BE01);
    rd(8'h00, v); chk("R3 ctrl word", v, 32'hDEAD_BE01);
    rd(8'h0C, a0);
    repeat (5) @(negedge clk);
    rd(8'h0C, b0); chk("R3 running", b0, a0 - 5);

    // R4 clearing start bit does not stop
    wr(8'h00, 32'h0000_0100);
    rd(8'h00, v); chk("R4 ctrl word", v, 32'h100);
    rd(8'h0C, a0);
    repeat (5) @(negedge clk);
    rd(8'h0C, b0); chk("R4 still running", b0, a0 - 5);

    // R7 running but no tick strobe
    tick_on = 0;
    rd(8'h0C, a0);
    repeat (4) @(negedge clk);
    rd(8'h0C, b0); chk("R7 no tick hold", b0, a0);
    tick_on = 1;

    // R2 soft reset discards start bit
    wr(8'h00, 32'hFFFF_FF03);
    rd(8'h00, v); chk("R2 ctrl cleared", v, 0);
    rd(8'h08, v); chk("R2 reload cleared", v, 0);
    rd(8'h0C, v); chk("R2 count cleared", v, 0);
    repeat (5) @(negedge clk);
    rd(8'h0C, v); chk("R2 stays stopped", v, 0);
    chk("R2 no wrap", {31'b0, wrap}, 0);

    // R9 zero reload while running
    wr(8'h00, 1);
    @(negedge clk);
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      rd(8'h0C, v); chk("R9 count stays zero", v, 0);
      chk("R9 wrap each tick", {31'b0, wrap}, 1);
    end

    // R8 period sweep, tick every cycle then every third cycle
    for (int pass = 0; pass < 2; pass++) begin
      tick_every = (pass == 0) ? 1 : 3;
      for (int r = 0; r < (1 << CW); r++) begin
        if (pass == 1 && !(r == 0 || r == 1 || r == 5 || r == 63)) continue;
        wr(8'h00, 2);
        wr(8'h08, r);
        wr(8'h00, 1);
        wait_wrap("R8 first wrap", n);
        rd(8'h0C, v); chk("R8 reloaded at wrap", v, r);
        wait_wrap("R8 second wrap", n);
        chk("R8 period", n, (r + 1) * tick_every);
      end
    end

    $display("[TB] %0d tests run, %0d failed", ntests, nfail);
    $finish;
  end
endmodule